// File: doc/BRIEF.md
# Row-Buffer Policy Classifier

This block decides which row-buffer management policy a memory controller uses, working only from latencies that an outside test harness has measured. The harness runs a pair of reads in which the second address differs from the first in one bit. It does this for each address bit in turn and streams the latency of the second read into the block, one beat per bit. The block builds its comparison thresholds from DRAM timing values, which arrive as static inputs. It tests every beat against intervals set by those thresholds. When the last beat of a sweep arrives, it reports open-page, close-page or undetermined. An undetermined result also raises a retry flag, so the harness can repeat the sweep with a different gap between the two requests.

Once a sweep has settled on open-page or close-page, the harness can stream a second kind of phase. This is the hybrid test, made of two halves. The first half carries latencies of reads to one bank with changing rows. The second half carries latencies of reads that stay in one row. If both halves show the expected short latencies, the verdict is upgraded to hybrid-page. Otherwise the earlier verdict is reported again. Issuing requests, spacing them and measuring time all happen outside this block.

Top module: `page_policy_classifier`

## Requirements
- R1: Thresholds are formed as lo = tCL, hit = tRCD+tCL, turn = hit+tBUS+tRTRS and miss = tRP+tRCD+tCL. A sweep in which at least one beat satisfies turn < latency < miss (both ends exclusive), and no beat satisfies R2, ends with verdict 2'b10 (close-page).
- R2: A sweep in which at least one beat satisfies lo <= latency < hit, and no beat satisfies R1, ends with verdict 2'b01 (open-page). A latency of lo-1 does not count as such a beat.
- R3: A sweep in which every beat equals hit exactly ends with verdict 2'b10 (close-page).
- R4: A sweep that meets none of R1, R2 or R3 ends with verdict 2'b00 (undetermined), and `retry` is high in the same cycle as `done`. `retry` is never high without `done`.
- R5: A sweep that contains both an R1 beat and an R2 beat ends with verdict 2'b00 and `retry` high.
- R6: `done` is a single-cycle pulse in the cycle after a beat with `lat_last` high. The beat carrying `lat_last` counts toward the verdict. `verdict` changes only when `done` is high.
- R7: A hybrid phase (`lat_phase`=1) is taken after a sweep that gave 2'b01 or 2'b10. If some first-half beat (`lat_half`=0) is below miss and some second-half beat (`lat_half`=1) is below hit, it ends with verdict 2'b11 (hybrid-page).
- R8: A hybrid phase that is taken but does not meet R7 ends with the verdict of the preceding sweep.
- R9: A hybrid phase that arrives after reset, or after a sweep that ended undetermined, is ignored. It produces no `done`, and `verdict` keeps its value.
- R10: Threshold sums saturate at the all-ones value of the latency width instead of wrapping.
- R11: While `rst_n` is low at a clock edge, `verdict` becomes 2'b00, and `done` and `retry` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| t_cl | input | TW | Column access latency in cycles |
| t_rcd | input | TW | Activate-to-column delay in cycles |
| t_rp | input | TW | Precharge time in cycles |
| t_bus | input | TW | Data burst duration in cycles |
| t_rtrs | input | TW | Rank-to-rank switch gap in cycles |
| lat_valid | input | 1 | Latency beat present this cycle |
| lat_last | input | 1 | Beat is the final one of its phase |
| lat_phase | input | 1 | 0 = bit sweep, 1 = hybrid test |
| lat_half | input | 1 | Hybrid beat half: 0 = row-changing, 1 = same-row |
| lat_value | input | LW | Measured latency of the second request |
| verdict | output | 2 | 00 undetermined, 01 open, 10 close, 11 hybrid |
| done | output | 1 | One-cycle pulse when a new verdict is posted |
| retry | output | 1 | Pulse with done when a sweep is undetermined |

## Verification
The end of a phase and the deciding observation can fall in the same cycle. This happens when the only latency inside an interval rides on the beat that also carries `lat_last`, so the verdict must fold in that beat as well as the stored evidence. The bench provokes this with directed sweeps whose single close-interval or open-interval latency sits on the final beat. The rest of each such sweep is made of row-miss latencies. The bench then requires the specific non-undetermined verdict in the cycle after that beat. Random sweeps put boundary values on arbitrary beats, including the last, and a bench model computes the verdict for each.

// File: rtl/ppc_pkg.sv
// Package: shared verdict encoding for the row-buffer policy classifier.
// Assumes: encodings are fixed; the harness relies on them.
package ppc_pkg;

    typedef enum logic [1:0] {
        VERD_UNDET  = 2'b00,
        VERD_OPEN   = 2'b01,
        VERD_CLOSE  = 2'b10,
        VERD_HYBRID = 2'b11
    } verdict_e;

endpackage

// File: rtl/ppc_bounds.sv
// Module: ppc_bounds
// Derives the latency thresholds used by the interval tests from the DRAM
// timing inputs. Purely combinational; every sum saturates at all-ones.
// Assumes: LW >= TW, timing inputs are quasi-static between phases.
module ppc_bounds #(
    parameter int TW = 10,
    parameter int LW = 10
) (
    input  logic [TW-1:0] t_cl,
    input  logic [TW-1:0] t_rcd,
    input  logic [TW-1:0] t_rp,
    input  logic [TW-1:0] t_bus,
    input  logic [TW-1:0] t_rtrs,
    output logic [LW-1:0] bnd_lo,
    output logic [LW-1:0] bnd_hit,
    output logic [LW-1:0] bnd_turn,
    output logic [LW-1:0] bnd_miss
);

    localparam logic [LW-1:0] SAT_MAX = '1;

    function automatic logic [LW-1:0] sat_add(input logic [LW-1:0] a,
                                              input logic [LW-1:0] b);
        logic [LW:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[LW] ? SAT_MAX : s[LW-1:0];
    endfunction

    logic [LW-1:0] cl_w, rcd_w, rp_w, bus_w, rtrs_w;
    logic [LW-1:0] burst_w;

    // Widen every timing input to the latency width.
    always_comb begin
        cl_w   = LW'(t_cl);
        rcd_w  = LW'(t_rcd);
        rp_w   = LW'(t_rp);
        bus_w  = LW'(t_bus);
        rtrs_w = LW'(t_rtrs);
    end

    // Chain of saturating sums forming the four thresholds.
    always_comb begin
        bnd_lo   = cl_w;
        bnd_hit  = sat_add(rcd_w, cl_w);
        burst_w  = sat_add(bnd_hit, bus_w);
        bnd_turn = sat_add(burst_w, rtrs_w);
        bnd_miss = sat_add(rp_w, bnd_hit);
    end

endmodule

// File: rtl/ppc_sweep_acc.sv
// Module: ppc_sweep_acc
// Collects evidence over one bit sweep: whether any beat fell in the
// close-only interval, whether any fell in the row-hit interval, and whether
// all beats so far equal the hit threshold. Outputs include the current beat
// so a decision on the final beat sees it. State clears after the final beat.
// Assumes: smp_valid is already qualified with the sweep phase.
module ppc_sweep_acc #(
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic          smp_last,
    input  logic [LW-1:0] smp_lat,
    input  logic [LW-1:0] bnd_lo,
    input  logic [LW-1:0] bnd_hit,
    input  logic [LW-1:0] bnd_turn,
    input  logic [LW-1:0] bnd_miss,
    output logic          seen_close,
    output logic          seen_open,
    output logic          all_hit
);

    logic close_q, open_q, allhit_q;
    logic in_close, in_open, at_hit;

    // Classify the current beat against the intervals.
    always_comb begin
        in_close = (smp_lat > bnd_turn) && (smp_lat < bnd_miss);
        in_open  = (smp_lat >= bnd_lo) && (smp_lat < bnd_hit);
        at_hit   = (smp_lat == bnd_hit);
    end

    // Merge stored evidence with the current beat.
    always_comb begin
        seen_close = close_q  | (smp_valid & in_close);
        seen_open  = open_q   | (smp_valid & in_open);
        all_hit    = allhit_q & (~smp_valid | at_hit);
    end

    // Hold evidence across beats; restart after the final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            close_q  <= 1'b0;
            open_q   <= 1'b0;
            allhit_q <= 1'b1;
        end else if (smp_valid) begin
            if (smp_last) begin
                close_q  <= 1'b0;
                open_q   <= 1'b0;
                allhit_q <= 1'b1;
            end else begin
                close_q  <= seen_close;
                open_q   <= seen_open;
                allhit_q <= all_hit;
            end
        end
    end

endmodule

// File: rtl/ppc_hybrid_acc.sv
// Module: ppc_hybrid_acc
// Collects evidence over one hybrid phase: a short latency (below the miss
// threshold) in the row-changing half, and a row-hit latency (below the hit
// threshold) in the same-row half. Outputs include the current beat.
// Assumes: smp_valid is qualified with the hybrid phase and a prior decision.
module ppc_hybrid_acc #(
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic          smp_last,
    input  logic          smp_half,
    input  logic [LW-1:0] smp_lat,
    input  logic [LW-1:0] bnd_hit,
    input  logic [LW-1:0] bnd_miss,
    output logic          first_low,
    output logic          second_low
);

    logic first_q, second_q;

    // Merge stored evidence with the current beat, per half.
    always_comb begin
        first_low  = first_q  | (smp_valid & ~smp_half & (smp_lat < bnd_miss));
        second_low = second_q | (smp_valid &  smp_half & (smp_lat < bnd_hit));
    end

    // Hold evidence across beats; restart after the final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q  <= 1'b0;
            second_q <= 1'b0;
        end else if (smp_valid) begin
            first_q  <= smp_last ? 1'b0 : first_low;
            second_q <= smp_last ? 1'b0 : second_low;
        end
    end

endmodule

// File: rtl/page_policy_classifier.sv
// Module: page_policy_classifier (top)
// Classifies a memory controller's row-buffer policy from streamed
// second-request latencies. Phase 0 is the per-bit sweep; phase 1 is the
// two-half hybrid test, honoured only after a sweep gave open or close.
// Verdict, done and retry are registered and update one cycle after the
// final beat of a phase.
// Assumes: the harness never interleaves beats of the two phases.
module page_policy_classifier
    import ppc_pkg::*;
#(
    parameter int TW = 10,
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] t_cl,
    input  logic [TW-1:0] t_rcd,
    input  logic [TW-1:0] t_rp,
    input  logic [TW-1:0] t_bus,
    input  logic [TW-1:0] t_rtrs,
    input  logic          lat_valid,
    input  logic          lat_last,
    input  logic          lat_phase,
    input  logic          lat_half,
    input  logic [LW-1:0] lat_value,
    output logic [1:0]    verdict,
    output logic          done,
    output logic          retry
);

    logic [LW-1:0] bnd_lo, bnd_hit, bnd_turn, bnd_miss;
    logic          sweep_vld, hyb_vld;
    logic          seen_close, seen_open, all_hit;
    logic          first_low, second_low;
    logic          sweep_end, hyb_end;
    verdict_e      sweep_dec, hyb_dec;
    verdict_e      verdict_q, prelim_v;
    logic          prelim_q, done_q, retry_q;

    ppc_bounds #(.TW(TW), .LW(LW)) u_bounds (
        .t_cl    (t_cl),
        .t_rcd   (t_rcd),
        .t_rp    (t_rp),
        .t_bus   (t_bus),
        .t_rtrs  (t_rtrs),
        .bnd_lo  (bnd_lo),
        .bnd_hit (bnd_hit),
        .bnd_turn(bnd_turn),
        .bnd_miss(bnd_miss)
    );

    // Qualify beats per phase; hybrid beats need a prior decision.
    always_comb begin
        sweep_vld = lat_valid & ~lat_phase;
        hyb_vld   = lat_valid &  lat_phase & prelim_q;
        sweep_end = sweep_vld & lat_last;
        hyb_end   = hyb_vld & lat_last;
    end

    ppc_sweep_acc #(.LW(LW)) u_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (sweep_vld),
        .smp_last  (lat_last),
        .smp_lat   (lat_value),
        .bnd_lo    (bnd_lo),
        .bnd_hit   (bnd_hit),
        .bnd_turn  (bnd_turn),
        .bnd_miss  (bnd_miss),
        .seen_close(seen_close),
        .seen_open (seen_open),
        .all_hit   (all_hit)
    );

    ppc_hybrid_acc #(.LW(LW)) u_hybrid (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (hyb_vld),
        .smp_last  (lat_last),
        .smp_half  (lat_half),
        .smp_lat   (lat_value),
        .bnd_hit   (bnd_hit),
        .bnd_miss  (bnd_miss),
        .first_low (first_low),
        .second_low(second_low)
    );

    // Sweep decision; conflicting evidence is treated as undetermined.
    always_comb begin
        if (seen_close && seen_open)
            sweep_dec = VERD_UNDET;
        else if (seen_close || all_hit)
            sweep_dec = VERD_CLOSE;
        else if (seen_open)
            sweep_dec = VERD_OPEN;
        else
            sweep_dec = VERD_UNDET;
    end

    // Hybrid decision: upgrade only when both halves show short latency.
    always_comb begin
        hyb_dec = (first_low && second_low) ? VERD_HYBRID : prelim_v;
    end

    // Post verdicts and track whether a preliminary decision exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= VERD_UNDET;
            prelim_v  <= VERD_UNDET;
            prelim_q  <= 1'b0;
            done_q    <= 1'b0;
            retry_q   <= 1'b0;
        end else begin
            done_q  <= sweep_end | hyb_end;
            retry_q <= sweep_end & (sweep_dec == VERD_UNDET);
            if (sweep_end) begin
                verdict_q <= sweep_dec;
                prelim_v  <= sweep_dec;
                prelim_q  <= (sweep_dec != VERD_UNDET);
            end else if (hyb_end) begin
                verdict_q <= hyb_dec;
            end
        end
    end

    assign verdict = verdict_q;
    assign done    = done_q;
    assign retry   = retry_q;

endmodule

// File: rtl/ppc_checker.sv
// Module: ppc_checker
// Temporal properties of the classifier's outputs, bound to the top.
// Assumes: prelim_q is the top's record of a non-undetermined sweep.
module ppc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       lat_valid,
    input logic       lat_last,
    input logic       lat_phase,
    input logic [1:0] verdict,
    input logic       done,
    input logic       retry,
    input logic       prelim_q
);

    a_r11_reset_state: assert property (@(posedge clk)
        !rst_n |=> (verdict == 2'b00 && !done && !retry));

    a_r4_retry_with_undet: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> (done && verdict == 2'b00));

    a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(lat_valid && lat_last));

    a_r6_verdict_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(verdict));

    a_r9_hybrid_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_valid && lat_last && lat_phase && !prelim_q) |=> !done);

    a_r7_hybrid_from_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (done && verdict == 2'b11) |-> $past(lat_phase && prelim_q));

endmodule

bind page_policy_classifier ppc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lat_valid(lat_valid),
    .lat_last (lat_last),
    .lat_phase(lat_phase),
    .verdict  (verdict),
    .done     (done),
    .retry    (retry),
    .prelim_q (prelim_q)
);

// File: tb/page_policy_classifier_tb.sv
module page_policy_classifier_tb;

    localparam int TW = 10;
    localparam int LW = 10;
    localparam int PW = 16;
    localparam int HN = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] t_cl = '0, t_rcd = '0, t_rp = '0, t_bus = '0, t_rtrs = '0;
    logic          lat_valid = 1'b0, lat_last = 1'b0, lat_phase = 1'b0, lat_half = 1'b0;
    logic [LW-1:0] lat_value = '0;
    logic [1:0]    verdict;
    logic          done, retry;

    int n_chk = 0;
    int n_fail = 0;

    int lats[PW];
    int hyb[2*HN];
    int e_prelim_ok = 0;
    int e_prelim_v = 0;
    int e_verdict = 0;
    int seed_dummy;

    always #2 clk = ~clk;

    page_policy_classifier #(.TW(TW), .LW(LW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .t_cl(t_cl), .t_rcd(t_rcd), .t_rp(t_rp), .t_bus(t_bus), .t_rtrs(t_rtrs),
        .lat_valid(lat_valid), .lat_last(lat_last), .lat_phase(lat_phase),
        .lat_half(lat_half), .lat_value(lat_value),
        .verdict(verdict), .done(done), .retry(retry)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int satl(input int v);
        return (v > 1023) ? 1023 : v;
    endfunction
    function automatic int b_lo();   return int'(t_cl); endfunction
    function automatic int b_hit();  return satl(int'(t_rcd) + int'(t_cl)); endfunction
    function automatic int b_turn(); return satl(satl(b_hit() + int'(t_bus)) + int'(t_rtrs)); endfunction
    function automatic int b_miss(); return satl(int'(t_rp) + b_hit()); endfunction

    function automatic int exp_sweep();
        bit c = 0, o = 0, a = 1;
        for (int i = 0; i < PW; i++) begin
            if (lats[i] > b_turn() && lats[i] < b_miss()) c = 1;
            if (lats[i] >= b_lo() && lats[i] < b_hit()) o = 1;
            if (lats[i] != b_hit()) a = 0;
        end
        if (c && o) return 0;
        if (c || a) return 2;
        if (o) return 1;
        return 0;
    endfunction

    function automatic int exp_hyb();
        bit f = 0, s = 0;
        for (int i = 0; i < 2*HN; i++) begin
            if (i < HN && hyb[i] < b_miss()) f = 1;
            if (i >= HN && hyb[i] < b_hit()) s = 1;
        end
        return (f && s) ? 3 : e_prelim_v;
    endfunction

    task automatic set_timing(input int cl, input int rcd, input int rp, input int bus, input int rtrs);
        t_cl = TW'(cl); t_rcd = TW'(rcd); t_rp = TW'(rp); t_bus = TW'(bus); t_rtrs = TW'(rtrs);
    endtask

    task automatic fill(input int v);
        for (int i = 0; i < PW; i++) lats[i] = v;
    endtask

    // Stream a sweep, then check verdict/done/retry against the model.
    task automatic run_sweep(input string req);
        int ev;
        ev = exp_sweep();
        for (int i = 0; i < PW; i++) begin
            @(negedge clk);
            lat_valid = 1'b1; lat_phase = 1'b0; lat_half = 1'b0;
            lat_last = (i == PW-1); lat_value = LW'(lats[i]);
        end
        @(negedge clk);
        lat_valid = 1'b0; lat_last = 1'b0;
        chk(done == 1'b1, {req, " done"}, int'(done), 1);
        chk(int'(verdict) == ev, {req, " verdict"}, int'(verdict), ev);
        chk(retry == (ev == 0), {req, " retry"}, int'(retry), int'(ev == 0));
        e_verdict = ev;
        e_prelim_ok = (ev != 0);
        e_prelim_v = ev;
        @(negedge clk);
        chk(done == 1'b0, "R6 done single pulse", int'(done), 0);
        chk(int'(verdict) == ev, "R6 verdict held", int'(verdict), ev);
    endtask

    task automatic run_hyb(input string req);
        int ev;
        ev = e_prelim_ok ? exp_hyb() : e_verdict;
        for (int i = 0; i < 2*HN; i++) begin
            @(negedge clk);
            lat_valid = 1'b1; lat_phase = 1'b1; lat_half = (i >= HN);
            lat_last = (i == 2*HN-1); lat_value = LW'(hyb[i]);
        end
        @(negedge clk);
        lat_valid = 1'b0; lat_last = 1'b0; lat_phase = 1'b0;
        chk(done == (e_prelim_ok != 0), {req, " done"}, int'(done), e_prelim_ok);
        chk(int'(verdict) == ev, {req, " verdict"}, int'(verdict), ev);
        chk(retry == 1'b0, {req, " retry"}, int'(retry), 0);
        e_verdict = ev;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(1234);
        set_timing(11, 11, 11, 4, 2); // lo=11 hit=22 turn=28 miss=33
        repeat (3) @(negedge clk);
        chk(verdict == 2'b00 && !done && !retry, "R11 reset state", int'(verdict), 0);
        rst_n = 1'b1;

        // R9: hybrid right after reset is ignored
        for (int i = 0; i < 2*HN; i++) hyb[i] = 5;
        run_hyb("R9 hybrid after reset");

        fill(22); run_sweep("R3 all hit");
        fill(40); run_sweep("R4 all miss");
        run_hyb("R9 hybrid after undetermined");
        fill(40); lats[3] = 21; run_sweep("R2 hit-1 beat");
        fill(40); lats[7] = 11; run_sweep("R2 lo beat");
        fill(40); lats[7] = 10; run_sweep("R2 lo-1 beat");
        fill(40); lats[0] = 29; run_sweep("R1 turn+1 beat");
        fill(40); lats[0] = 28; run_sweep("R1 turn beat excluded");
        fill(40); lats[5] = 33; run_sweep("R1 miss beat excluded");
        fill(40); lats[PW-1] = 32; run_sweep("R1 on last beat");
        fill(40); lats[PW-1] = 15; run_sweep("R2 on last beat");
        fill(22); lats[PW-1] = 23; run_sweep("R3 broken on last beat");
        fill(40); lats[2] = 30; lats[9] = 12; run_sweep("R5 conflict");

        // R7/R8 directed, preliminary close
        fill(22); run_sweep("R3 prelim");
        for (int i = 0; i < 2*HN; i++) hyb[i] = 40;
        hyb[1] = 32; hyb[2*HN-1] = 21;
        run_hyb("R7 hybrid upgrade");
        hyb[1] = 40;
        run_hyb("R8 first half no short");
        hyb[1] = 30; hyb[2*HN-1] = 22;
        run_hyb("R8 second half at hit");

        // R10 saturation: miss = 1023
        set_timing(400, 400, 400, 4, 2);
        fill(1100 % 1024); lats[4] = 1000; run_sweep("R10 saturated miss");
        fill(1023); run_sweep("R10 saturated miss excluded");

        // Random mix
        set_timing(11, 11, 11, 4, 2);
        for (int r = 0; r < 60; r++) begin
            for (int i = 0; i < PW; i++) begin
                if ($urandom_range(7) == 0) lats[i] = $urandom_range(45);
                else if ($urandom_range(3) == 0) lats[i] = 22;
                else lats[i] = 33 + $urandom_range(20);
            end
            if ($urandom_range(5) == 0) fill(22);
            run_sweep("R1 R2 R3 R4 random sweep");
            for (int i = 0; i < 2*HN; i++) hyb[i] = $urandom_range(10, 60);
            run_hyb("R7 R8 R9 random hybrid");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule